// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block is the host-visible control face of one bus-master disk DMA channel. Three registers sit behind a small byte-enabled register bus: a command byte, a status byte and a 32-bit descriptor table base. The block converts host writes into one-cycle start and stop strobes for a separate DMA engine. It also collects completion and error flags from that engine. The descriptor walking and the data movement are done elsewhere.

The bus has two 32-bit words. Word 0 carries the command byte in lane 0 and the status byte in lane 2. Word 1 is the table base. Each byte lane is written only when its byte enable is set, so 1-, 2- and 4-byte accesses all work, with little-endian lane placement. Stopping is graceful. When the host clears the start bit while the engine reports a transfer in flight, the block holds the stop until the engine goes idle. The drive interrupt is forwarded to the host and is also latched into the status byte.

Top module: `bmdma_ctrl_regs`

## Requirements
- R1: After reset the command byte, status byte and table base read as zero, and start_req, stop_req, ptr_reload, xfer_dir and host_irq are all 0.
- R2: A command write that changes the start bit (bit 0) from 0 to 1 while the active flag (status bit 0) is clear pulses ptr_reload and start_req for one cycle, starting at the clock edge that takes the write. The active flag is set at that same edge.
- R3: A command write that changes the start bit from 0 to 1 while the active flag is still set pulses ptr_reload only. start_req stays 0 and the active flag stays set.
- R4: A command write that leaves the start bit at its current value pulses none of start_req, stop_req or ptr_reload. The direction bit is still updated.
- R5: A command write that changes the start bit from 1 to 0 while eng_busy is 0 pulses stop_req for one cycle and clears the active flag at the edge that takes the write.
- R6: A command write that changes the start bit from 1 to 0 while eng_busy is 1 does not abort the transfer. stop_req stays 0 and the active flag stays set until eng_busy is sampled low. At that edge stop_req pulses and the active flag clears.
- R7: The command byte stores only bit 0 (start) and bit 3 (direction), so a read returns the write ANDed with 0x09. xfer_dir follows bit 3.
- R8: Word 1 (the table base) writes each byte lane whose enable is set and keeps the other lanes. Bits 1:0 always read as zero, and tbl_base equals the read value.
- R9: A rising edge on drv_irq sets status bit 2 (interrupt). host_irq equals drv_irq delayed by one clock, on both rising and falling edges.
- R10: eng_err sets status bit 1 and eng_int sets status bit 2. An eng_inactive pulse clears the active flag.
- R11: In the status byte (word 0, lane 2), writing 1 to bit 1 or bit 2 clears that bit and writing 0 leaves it. Host writes do not change bit 0. Bits 5 and 6 are plain read/write flags.
- R12: When a set source (drv_irq rising, eng_err or eng_int) and a host write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 1 | Word select: 0 command/status, 1 table base |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| drv_irq | input | 1 | Drive interrupt level |
| eng_busy | input | 1 | Engine has a transfer in flight |
| eng_err | input | 1 | Engine sets the error flag |
| eng_int | input | 1 | Engine sets the interrupt flag |
| eng_inactive | input | 1 | Engine went inactive; clears the active flag |
| start_req | output | 1 | One-cycle trigger to the engine |
| stop_req | output | 1 | One-cycle stop taking effect |
| ptr_reload | output | 1 | Reload the current descriptor pointer from tbl_base |
| xfer_dir | output | 1 | Transfer direction (command bit 3) |
| tbl_base | output | 32 | Descriptor table base |
| host_irq | output | 1 | Forwarded interrupt level |

## Verification
Two functions can act on the interrupt bit in the same cycle: the latch of a rising drive interrupt and the host's write-1-to-clear of that bit. The bench first sets the bit. It then drives a write-1-to-clear to status lane 2 in the very clock cycle where drv_irq rises, and expects the bit to read back set. A separate write-1-to-clear with no competing edge must then clear it. The error bit gets the same treatment, with eng_err raised together with the clear. A deferred stop is checked against the same edge that releases eng_busy.

// File: rtl/bmdma_ctrl_regs.sv
module bmdma_ctrl_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_word,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        drv_irq,
  input  logic        eng_busy,
  input  logic        eng_err,
  input  logic        eng_int,
  input  logic        eng_inactive,
  output logic        start_req,
  output logic        stop_req,
  output logic        ptr_reload,
  output logic        xfer_dir,
  output logic [31:0] tbl_base,
  output logic        host_irq
);
  localparam logic [7:0] CMD_MASK = 8'h09;

  logic [7:0]  cmd_q;
  logic        act_q, err_q, int_q, f5_q, f6_q;
  logic        stop_pend_q, irq_q;
  logic [31:0] tbl_q;

  logic cmd_wr, sts_wr, go, halt, stop_now, irq_rise;
  logic [7:0] sts_wb;
  logic [31:0] tbl_nx;
  logic act_nx;

  assign cmd_wr   = reg_wr & ~reg_word & reg_be[0];
  assign sts_wr   = reg_wr & ~reg_word & reg_be[2];
  assign sts_wb   = reg_wdata[23:16];
  assign go       = cmd_wr & reg_wdata[0] & ~cmd_q[0];
  assign halt     = cmd_wr & ~reg_wdata[0] & cmd_q[0];
  assign stop_now = ~eng_busy & (halt | (stop_pend_q & ~go));
  assign irq_rise = drv_irq & ~irq_q;

  always_comb begin
    for (int i = 0; i < 4; i++)
      tbl_nx[8*i +: 8] = (reg_wr & reg_word & reg_be[i]) ? reg_wdata[8*i +: 8] : tbl_q[8*i +: 8];
    tbl_nx[1:0] = 2'b00;
  end

  always_comb begin
    act_nx = act_q;
    if (stop_now | eng_inactive) act_nx = 1'b0;
    if (go & ~act_q)             act_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      act_q       <= 1'b0;
      err_q       <= 1'b0;
      int_q       <= 1'b0;
      f5_q        <= 1'b0;
      f6_q        <= 1'b0;
      stop_pend_q <= 1'b0;
      irq_q       <= 1'b0;
      tbl_q       <= '0;
      start_req   <= 1'b0;
      stop_req    <= 1'b0;
      ptr_reload  <= 1'b0;
      host_irq    <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= reg_wdata[7:0] & CMD_MASK;
      act_q      <= act_nx;
      start_req  <= go & ~act_q;
      ptr_reload <= go;
      stop_req   <= stop_now;
      if (halt & eng_busy)      stop_pend_q <= 1'b1;
      else if (go | stop_now)   stop_pend_q <= 1'b0;
      err_q <= (err_q & ~(sts_wr & sts_wb[1])) | eng_err;
      int_q <= (int_q & ~(sts_wr & sts_wb[2])) | eng_int | irq_rise;
      if (sts_wr) begin
        f5_q <= sts_wb[5];
        f6_q <= sts_wb[6];
      end
      irq_q    <= drv_irq;
      host_irq <= drv_irq;
      tbl_q    <= tbl_nx;
    end
  end

  assign xfer_dir  = cmd_q[3];
  assign tbl_base  = tbl_q;
  assign reg_rdata = reg_word ? tbl_q
                   : {8'h00, 1'b0, f6_q, f5_q, 2'b00, int_q, err_q, act_q, 8'h00, cmd_q};
endmodule

module bmdma_ctrl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_word,
  input logic [3:0]  reg_be,
  input logic [31:0] reg_wdata,
  input logic [7:0]  cmd_q,
  input logic        act_q,
  input logic        int_q,
  input logic        eng_busy,
  input logic        drv_irq,
  input logic        start_req,
  input logic        stop_req,
  input logic        ptr_reload,
  input logic        host_irq,
  input logic [31:0] tbl_base
);
  AST_SAME_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_word && reg_be[0] && reg_wdata[0] == cmd_q[0]) |=> (!start_req && !ptr_reload)); // R4
  AST_START_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> (act_q && ptr_reload)); // R2
  AST_STOP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> ($past(!eng_busy) && !act_q)); // R6
  AST_TABLE_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_word && reg_be[0]) |=> (tbl_base[7:2] == $past(reg_wdata[7:2]))); // R8
  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == $past(drv_irq)); // R9
  AST_IRQ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_irq) |=> int_q); // R9
endmodule

bind bmdma_ctrl_regs bmdma_ctrl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word), .reg_be(reg_be),
  .reg_wdata(reg_wdata), .cmd_q(cmd_q), .act_q(act_q), .int_q(int_q), .eng_busy(eng_busy),
  .drv_irq(drv_irq), .start_req(start_req), .stop_req(stop_req), .ptr_reload(ptr_reload),
  .host_irq(host_irq), .tbl_base(tbl_base)
);

// File: tb/test_bmdma_ctrl_regs.sv
`timescale 1ns/1ps
module test_bmdma_ctrl_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_word = 1'b0;
  logic [3:0] reg_be = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic drv_irq = 1'b0, eng_busy = 1'b0, eng_err = 1'b0, eng_int = 1'b0, eng_inactive = 1'b0;
  logic start_req, stop_req, ptr_reload, xfer_dir, host_irq;
  logic [31:0] tbl_base;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bmdma_ctrl_regs i_bmdma_ctrl_regs (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic word, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_word = word; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic rd(logic word, output logic [31:0] d);
    reg_word = word; #0.1; d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d); chk("R1 word0", d, 0);
    rd(1, d); chk("R1 word1", d, 0);
    chk("R1 outputs", {start_req, stop_req, ptr_reload, xfer_dir, host_irq}, 0);
  endtask

  task automatic t_start_stop;
    logic [31:0] d;
    wr(0, 4'b0001, 32'h0000_00ff);
    chk("R2 start/reload", {start_req, ptr_reload}, 2'b11);
    rd(0, d); chk("R2 active", d[16], 1);
    chk("R7 cmd mask", d[7:0], 8'h09);
    chk("R7 dir", xfer_dir, 1);
    @(negedge clk); chk("R2 one-cycle pulse", {start_req, ptr_reload}, 0);
    wr(0, 4'b0001, 32'h0000_0001);
    chk("R4 no strobes", {start_req, stop_req, ptr_reload}, 0);
    chk("R4 dir updated", xfer_dir, 0);
    wr(0, 4'b0001, 32'h0);
    chk("R5 stop_req", stop_req, 1);
    rd(0, d); chk("R5 inactive", d[16], 0);
    wr(0, 4'b0001, 32'h0);
    chk("R4 no stop when unchanged", {start_req, stop_req, ptr_reload}, 0);
  endtask

  task automatic t_busy_stop;
    logic [31:0] d;
    wr(0, 4'b0001, 32'h1);
    eng_busy = 1'b1;
    wr(0, 4'b0001, 32'h0);
    chk("R6 stop held", stop_req, 0);
    rd(0, d); chk("R6 still active", d[16], 1);
    repeat (3) @(negedge clk);
    chk("R6 still held", stop_req, 0);
    wr(0, 4'b0001, 32'h1);
    chk("R3 reload only", {start_req, ptr_reload}, 2'b01);
    rd(0, d); chk("R3 active kept", d[16], 1);
    wr(0, 4'b0001, 32'h0);
    chk("R6 held again", stop_req, 0);
    eng_busy = 1'b0;
    @(negedge clk);
    chk("R6 stop after idle", stop_req, 1);
    rd(0, d); chk("R6 active cleared", d[16], 0);
  endtask

  task automatic t_table;
    logic [31:0] d;
    wr(1, 4'b1111, 32'hdead_beef);
    rd(1, d); chk("R8 full write", d, 32'hdead_beec);
    chk("R8 tbl_base", tbl_base, 32'hdead_beec);
    wr(1, 4'b0100, 32'h0055_0000);
    rd(1, d); chk("R8 byte lane 2", d, 32'hde55_beec);
    wr(1, 4'b0011, 32'h0000_1237);
    rd(1, d); chk("R8 half lanes", d, 32'hde55_1234);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    @(negedge clk); drv_irq = 1'b1;
    @(negedge clk); chk("R9 host_irq rise", host_irq, 1);
    rd(0, d); chk("R9 int latched", d[18], 1);
    drv_irq = 1'b0;
    @(negedge clk); chk("R9 host_irq fall", host_irq, 0);
    rd(0, d); chk("R9 int kept on fall", d[18], 1);
    wr(0, 4'b0100, 32'h0000_0000);
    rd(0, d); chk("R11 write 0 keeps", d[18], 1);
    @(negedge clk);
    reg_wr = 1'b1; reg_word = 0; reg_be = 4'b0100; reg_wdata = 32'h0004_0000; drv_irq = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_be = '0;
    rd(0, d); chk("R12 set beats clear int", d[18], 1);
    wr(0, 4'b0100, 32'h0004_0000);
    rd(0, d); chk("R11 W1C int", d[18], 0);
    drv_irq = 1'b0; @(negedge clk);
  endtask

  task automatic t_engine;
    logic [31:0] d;
    @(negedge clk); eng_err = 1'b1;
    @(negedge clk); eng_err = 1'b0;
    rd(0, d); chk("R10 err set", d[17], 1);
    @(negedge clk); eng_int = 1'b1;
    @(negedge clk); eng_int = 1'b0;
    rd(0, d); chk("R10 int set", d[18], 1);
    wr(0, 4'b0100, 32'h0006_0000);
    rd(0, d); chk("R11 W1C both", d[18:17], 0);
    @(negedge clk);
    reg_wr = 1'b1; reg_word = 0; reg_be = 4'b0100; reg_wdata = 32'h0002_0000; eng_err = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_be = '0; eng_err = 1'b0;
    rd(0, d); chk("R12 set beats clear err", d[17], 1);
    wr(0, 4'b0100, 32'h0063_0000);
    rd(0, d); chk("R11 flags and bit0", d[23:16], 8'h60);
    wr(0, 4'b0001, 32'h1);
    @(negedge clk); eng_inactive = 1'b1;
    @(negedge clk); eng_inactive = 1'b0;
    rd(0, d); chk("R10 inactive clears active", d[16], 0);
    chk("R10 no stop strobe", stop_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start_stop();
    t_busy_stop();
    t_table();
    t_irq();
    t_engine();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule